// File: doc/BRIEF.md
# CPU Clock-Enable Prescaler with One-Hot Ratio Select

This block slows the processor's effective rate below the oscillator rate without creating a new clock. It runs entirely on the oscillator clock and emits `cpu_ce`, an enable pulse one oscillator cycle wide that the processor logic qualifies its flops with. A byte-wide configuration register on a small synchronous register bus holds a 6-bit ratio select. Zero means no division. A single set bit at position i selects a ratio of 2^(i+1), so ratios from 2 up to 64 are possible. Every other code falls back to the slowest ratio, 64. A registered, glitch-free divided clock `div_clk` with 50% duty is also provided for observation.

A two-state machine does the dividing. In state ST_BYPASS (ratio 1) the enable is high in every cycle. In state ST_DIVIDE a 6-bit counter runs from 0 to N-1 and the enable fires in the last count. Both states reach a period boundary when the enable fires, and only there does the machine load the ratio decoded from the register:
- T_STAY_BYPASS: ST_BYPASS to ST_BYPASS when the new ratio is 1.
- T_START_DIV: ST_BYPASS to ST_DIVIDE when the new ratio is 2 or more.
- T_RELOAD: ST_DIVIDE to ST_DIVIDE at a boundary when the new ratio is 2 or more.
- T_STOP_DIV: ST_DIVIDE to ST_BYPASS at a boundary when the new ratio is 1.
- T_COUNT: ST_DIVIDE to ST_DIVIDE between boundaries.

Top module: `cpuclk_prescaler`

## Requirements
- R1: A write with `reg_we` high and `reg_addr` = 0x2E stores `reg_wdata[5:0]` at the next rising edge. Writes to any other address leave the stored select and the divide ratio unchanged.
- R2: `reg_rdata` is combinational. While `reg_addr` = 0x2E it returns the stored select exactly as written, including invalid codes, in bits 5:0. At any other address it reads 0x00.
- R3: Register bits 7 and 6 are ignored on write and always read as zero. Writing 0xFF reads back 0x3F and gives ratio 64. Writing 0xC0 reads back 0x00 and gives ratio 1.
- R4: `rst` is synchronous and active high. While it is asserted, `cpu_ce` and `div_clk` are low. After it is released, the select reads 0x00, `cpu_ce` is high in every cycle and `div_clk` is low.
- R5: Select 000000 gives ratio 1: `cpu_ce` is high in every cycle and `div_clk` stays low.
- R6: A select with only bit i set (000001, 000010, 000100, 001000, 010000, 100000) gives ratio N = 2^(i+1). `cpu_ce` is high for exactly one cycle in every N cycles.
- R7: Any nonzero select that has more than one bit set gives ratio 64.
- R8: A new ratio takes effect only at the next period boundary. The enable pulse that closes the current period arrives at the old spacing, and pulses after it follow the new spacing. Starting from ratio 1, the boundary falls in the cycle right after the write.
- R9: For ratio N of 2 or more, `div_clk` is high for the first N/2 cycles of each period, counted from the cycle after an enable pulse, and low for the last N/2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register bus address |
| reg_we | input | 1 | Register bus write strobe |
| reg_wdata | input | 8 | Register bus write data |
| reg_rdata | output | 8 | Register bus read data (combinational) |
| cpu_ce | output | 1 | Single-cycle CPU clock-enable pulse at the divided rate |
| div_clk | output | 1 | Registered 50% divided clock for observation |

## Verification
Results fall due at different times, and the bench samples each one accordingly:
- Read data follows the register one edge after a write, so the bench reads it back at the falling edge that ends the write cycle.
- A new ratio appears only after the current period closes, which takes up to 64 cycles plus one load edge. Steady-state checks therefore wait 140 cycles after each write.
- In steady state, pulse counts and `div_clk` high-time are summed over a 512-cycle window. That window is a whole number of periods for every ratio, so the expected totals 512/N and 256 hold whatever the phase.
- Boundary behaviour is checked by measuring the gap between consecutive pulses around a write placed at a known offset after a pulse. The gap that closes the old period must sum to the old N, and the gap after it must equal the new N.

// File: rtl/pscl_pkg.sv
package pscl_pkg;
    typedef enum logic [0:0] {
        ST_BYPASS = 1'b0,
        ST_DIVIDE = 1'b1
    } pscl_state_e;
endpackage

// File: rtl/pscl_cfg_reg.sv
module pscl_cfg_reg #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int SEL_W    = 6,
    parameter int REG_ADDR = 8'h2E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [SEL_W-1:0]  sel
);
    logic hit;

    assign hit = (addr == ADDR_W'(REG_ADDR));

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= '0;
        end else if (we && hit) begin
            sel <= wdata[SEL_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata[SEL_W-1:0] = sel;
        end
    end
endmodule

// File: rtl/pscl_ratio_dec.sv
module pscl_ratio_dec #(
    parameter int SEL_W = 6,
    parameter int KW    = 3
) (
    input  logic [SEL_W-1:0] sel,
    output logic [KW-1:0]    log2_ratio
);
    logic [SEL_W-1:0] hit;

    for (genvar g = 0; g < SEL_W; g++) begin : g_hit
        assign hit[g] = (sel == (SEL_W'(1) << g));
    end

    always_comb begin
        log2_ratio = KW'(SEL_W);
        if (sel == '0) begin
            log2_ratio = '0;
        end else begin
            for (int i = 0; i < SEL_W; i++) begin
                if (hit[i]) begin
                    log2_ratio = KW'(i + 1);
                end
            end
        end
    end
endmodule

// File: rtl/pscl_div_fsm.sv
module pscl_div_fsm
    import pscl_pkg::*;
#(
    parameter int SEL_W = 6,
    parameter int KW    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [KW-1:0]     next_k,
    output logic              ce,
    output logic [KW-1:0]     act_k,
    output pscl_state_e       st_n,
    output logic [SEL_W-1:0]  cnt_n,
    output logic [KW-1:0]     k_n
);
    pscl_state_e      st;
    logic [SEL_W-1:0] cnt;
    logic [SEL_W-1:0] last;
    logic             ce_raw;

    assign last = {SEL_W{1'b1}} >> (KW'(SEL_W) - act_k);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_BYPASS;
            cnt   <= '0;
            act_k <= '0;
        end else begin
            st    <= st_n;
            cnt   <= cnt_n;
            act_k <= k_n;
        end
    end

    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        k_n    = act_k;
        ce_raw = 1'b0;
        unique case (st)
            ST_BYPASS: begin
                ce_raw = 1'b1;
                cnt_n  = '0;
                k_n    = next_k;
                st_n   = (next_k == '0) ? ST_BYPASS : ST_DIVIDE;
            end
            ST_DIVIDE: begin
                if (cnt == last) begin
                    ce_raw = 1'b1;
                    cnt_n  = '0;
                    k_n    = next_k;
                    st_n   = (next_k == '0) ? ST_BYPASS : ST_DIVIDE;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            default: begin
                st_n = ST_BYPASS;
            end
        endcase
    end

    assign ce = ce_raw & ~rst;
endmodule

// File: rtl/pscl_obs_clk.sv
module pscl_obs_clk
    import pscl_pkg::*;
#(
    parameter int SEL_W = 6,
    parameter int KW    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  pscl_state_e       st_n,
    input  logic [SEL_W-1:0]  cnt_n,
    input  logic [KW-1:0]     k_n,
    output logic              div_clk
);
    logic [SEL_W-1:0] last_n;
    logic [SEL_W-1:0] half_n;
    logic             obs_d;

    assign last_n = {SEL_W{1'b1}} >> (KW'(SEL_W) - k_n);
    assign half_n = last_n >> 1;
    assign obs_d  = (st_n == ST_DIVIDE) && (cnt_n <= half_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_clk <= 1'b0;
        end else begin
            div_clk <= obs_d;
        end
    end
endmodule

// File: rtl/cpuclk_prescaler.sv
module cpuclk_prescaler
    import pscl_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int SEL_W    = 6,
    parameter int REG_ADDR = 8'h2E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              cpu_ce,
    output logic              div_clk
);
    localparam int KW = $clog2(SEL_W + 1);

    logic [SEL_W-1:0] sel_q;
    logic [KW-1:0]    next_k;
    logic [KW-1:0]    act_k;
    pscl_state_e      st_n;
    logic [SEL_W-1:0] cnt_n;
    logic [KW-1:0]    k_n;

    pscl_cfg_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .REG_ADDR(REG_ADDR)
    ) u_cfg (
        .clk(clk), .rst(rst), .addr(reg_addr), .we(reg_we),
        .wdata(reg_wdata), .rdata(reg_rdata), .sel(sel_q)
    );

    pscl_ratio_dec #(.SEL_W(SEL_W), .KW(KW)) u_dec (
        .sel(sel_q), .log2_ratio(next_k)
    );

    pscl_div_fsm #(.SEL_W(SEL_W), .KW(KW)) u_fsm (
        .clk(clk), .rst(rst), .next_k(next_k), .ce(cpu_ce),
        .act_k(act_k), .st_n(st_n), .cnt_n(cnt_n), .k_n(k_n)
    );

    pscl_obs_clk #(.SEL_W(SEL_W), .KW(KW)) u_obs (
        .clk(clk), .rst(rst), .st_n(st_n), .cnt_n(cnt_n), .k_n(k_n),
        .div_clk(div_clk)
    );
endmodule

// File: rtl/pscl_checker.sv
module pscl_checker #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int SEL_W    = 6,
    parameter int REG_ADDR = 8'h2E,
    parameter int KW       = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              cpu_ce,
    input logic [SEL_W-1:0]  sel,
    input logic [KW-1:0]     next_k,
    input logic [KW-1:0]     act_k
);
    p_cfg_write_r1: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == ADDR_W'(REG_ADDR)) |=> sel == $past(reg_wdata[SEL_W-1:0]));

    p_cfg_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == ADDR_W'(REG_ADDR)) |=> $stable(sel));

    p_unused_zero_r3: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[DATA_W-1:SEL_W] == '0);

    p_bypass_ce_r5: assert property (@(posedge clk) disable iff (rst)
        (act_k == '0) |-> cpu_ce);

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        (cpu_ce && act_k != '0 && next_k != '0) |=> !cpu_ce);

    p_invalid_slowest_r7: assert property (@(posedge clk) disable iff (rst)
        ($countones(sel) > 1) |-> next_k == KW'(SEL_W));

    p_boundary_only_r8: assert property (@(posedge clk) disable iff (rst)
        !cpu_ce |=> $stable(act_k));
endmodule

bind cpuclk_prescaler pscl_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .REG_ADDR(REG_ADDR), .KW(KW)
) u_chk (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_ce(cpu_ce),
    .sel(sel_q), .next_k(next_k), .act_k(act_k)
);

// File: tb/cpuclk_prescaler_test.sv
`timescale 1ns/1ps
module cpuclk_prescaler_test;
    localparam logic [7:0] RA = 8'h2E;
    localparam int WIN = 512;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] reg_addr = RA;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       cpu_ce;
    logic       div_clk;

    int n_cmp = 0;
    int n_bad = 0;

    cpuclk_prescaler uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_ce(cpu_ce),
        .div_clk(div_clk)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = RA;
    endtask

    task automatic next_gap(output int g);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!cpu_ce);
    endtask

    task automatic measure(output int pulses, output int highs);
        pulses = 0; highs = 0;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            if (cpu_ce) pulses++;
            if (div_clk) highs++;
        end
    endtask

    task automatic run_code(input logic [7:0] code, input logic [7:0] rb, input int n, input string req);
        int p, h, g;
        wr(RA, code);
        check(reg_rdata == rb, {req, " R2 readback"}, reg_rdata, rb);
        repeat (140) @(negedge clk);
        next_gap(g);
        next_gap(g);
        check(g == n, {req, " pulse gap"}, g, n);
        measure(p, h);
        check(p == WIN / n, {req, " pulse count"}, p, WIN / n);
        if (n > 1) check(h == WIN / 2, "R9 div_clk high time", h, WIN / 2);
        else       check(h == 0, "R5 div_clk low at ratio 1", h, 0);
    endtask

    task automatic mid_change(input logic [7:0] newc, input int oldn, input int newn, input int off);
        int g;
        next_gap(g);
        repeat (off) @(negedge clk);
        wr(RA, newc);
        next_gap(g);
        check(off + 1 + g == oldn, "R8 closing gap at old ratio", off + 1 + g, oldn);
        next_gap(g);
        check(g == newn, "R8 first gap at new ratio", g, newn);
    endtask

    initial begin
        #(8.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int p, h, g;
        repeat (4) @(negedge clk);
        check(cpu_ce == 1'b0, "R4 ce low in reset", cpu_ce, 0);
        check(div_clk == 1'b0, "R4 div_clk low in reset", div_clk, 0);
        rst = 1'b0;
        @(negedge clk);
        check(reg_rdata == 8'h00, "R4 reset select", reg_rdata, 0);
        check(cpu_ce == 1'b1, "R4 ce high after reset", cpu_ce, 1);
        check(div_clk == 1'b0, "R4 div_clk low after reset", div_clk, 0);
        measure(p, h);
        check(p == WIN, "R5 continuous enable", p, WIN);

        for (int i = 1; i <= 6; i++)
            run_code(8'(1 << (i - 1)), 8'(1 << (i - 1)), 1 << i, "R6");
        run_code(8'h00, 8'h00, 1, "R5");

        run_code(8'h03, 8'h03, 64, "R7");
        run_code(8'h3F, 8'h3F, 64, "R7");
        run_code(8'h2A, 8'h2A, 64, "R7");
        run_code(8'h11, 8'h11, 64, "R7");

        run_code(8'hFF, 8'h3F, 64, "R3");
        run_code(8'hC0, 8'h00, 1, "R3");

        wr(8'h2F, 8'h01);
        check(reg_rdata == 8'h00, "R1 foreign write ignored", reg_rdata, 0);
        reg_addr = 8'h2F;
        @(negedge clk);
        check(reg_rdata == 8'h00, "R2 foreign address reads zero", reg_rdata, 0);
        reg_addr = RA;
        measure(p, h);
        check(p == WIN, "R1 ratio unchanged by foreign write", p, WIN);

        wr(RA, 8'h04);
        check(cpu_ce == 1'b1, "R8 boundary right after write from ratio 1", cpu_ce, 1);
        next_gap(g);
        check(g == 8, "R8 new ratio from ratio 1", g, 8);

        run_code(8'h20, 8'h20, 64, "R6");
        mid_change(8'h02, 64, 4, 20);
        mid_change(8'h20, 4, 64, 1);
        mid_change(8'h04, 64, 8, 50);
        mid_change(8'h00, 8, 1, 3);
        next_gap(g);
        check(g == 1, "R8 stays at ratio 1", g, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule